// File: doc/BRIEF.md
# Iterative Tweakable Cipher Round Sequencer

This block drives a tweakable block cipher that completes one round per clock. A one-cycle start pulse loads a 128-bit block, a 128-bit key and a 128-bit tweak. The block then runs 10 steps of 2 rounds each, 20 rounds in all. In every busy cycle it applies one round, using the current tweak key and a 16-bit constant built from the step and round indices. At the last round of each step it refreshes the tweak key.

The same schedule signals that drive the internal datapath also appear on the ports, so a neighbouring unit can follow the schedule: a busy flag, a tweak-refresh strobe and the round constant. When the twentieth round has been applied, a done pulse is raised and the result register is loaded. That register keeps its value until the next block finishes.

The substitution layer and the linear layer are simple stand-in functions. They are fixed so that results can be predicted exactly.

Top module: `tbc_round_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `busy_o`, `done_o` and `tk_upd_o` are 0, and `rc_o` and `result_o` are all zeros. Asserting reset in the middle of a block returns the block to idle with both counters at zero.
- R2: A start pulse seen at a clock edge while the block is idle makes `busy_o` read 1 from the next cycle onward.
- R3: `done_o` is high for exactly one cycle. It is first seen 20 clock edges after the edge that accepted the start. In that same cycle `busy_o` is 0.
- R4: In busy cycle i (i = 0..19, counted from the accepting edge), `rc_o` equals {4'b0, step[3:0], 7'b0, round}, where step = i/2 and round = i mod 2.
- R5: `tk_upd_o` is high exactly in the busy cycles where round = 1. This gives 10 pulses per block.
- R6: Let t0 = tweak, and let t(s+1) = t(s) rotated left by 8 bits; this means the tweak key changes only between steps. Each round computes x = state ^ key ^ t(step) ^ zero-extended rc. It then applies the byte map b -> b ^ (rotl1(b) & rotl2(b)) ^ 8'h5A to every byte, giving y. The new state is y ^ rotl(y,29) ^ rotl(y,77). `result_o` is the state after round 20.
- R7: `result_o` changes only in the cycle in which `done_o` is high. It holds its value while idle and while the next block runs.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored. It does not change the schedule, the done timing or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| start_i | input | 1 | Start pulse; loads block, key and tweak when idle |
| block_i | input | 128 | Input block |
| key_i | input | 128 | Cipher key |
| tweak_i | input | 128 | Initial tweak |
| busy_o | output | 1 | A round is applied in this cycle |
| tk_upd_o | output | 1 | Tweak key refreshes at the end of this cycle |
| rc_o | output | 16 | Round constant for this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Result after 20 rounds; held between completions |

## Verification
Inputs are driven on the falling edge, so the start is accepted at the next rising edge E0. The schedule outputs for busy cycle i are then due in the half cycle after edge E(i), for i = 0..19. Done, the cleared busy flag and the new result are due after edge E20, and the fall of done is due after edge E21. The bench walks this timeline one falling edge at a time and compares every value at the exact cycle the requirements give. It compares the result with a model built from the R6 definition. It also checks that the previous result stays unchanged during all 20 busy cycles, and that a start injected while busy leaves the timing and the result unchanged.

// File: rtl/tbc_seq_pkg.sv
package tbc_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Stand-in nonlinear byte map for the substitution layer.
  function automatic logic [7:0] sub_byte(input logic [7:0] b);
    logic [7:0] r1;
    logic [7:0] r2;
    r1 = {b[6:0], b[7]};
    r2 = {b[5:0], b[7:6]};
    return b ^ (r1 & r2) ^ 8'h5A;
  endfunction

endpackage

// File: rtl/tbc_sub_layer.sv
module tbc_sub_layer #(
  parameter int BLK_W = 128
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  localparam int NBYTES = BLK_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign dout[g*8 +: 8] = tbc_seq_pkg::sub_byte(din[g*8 +: 8]);
  end

endmodule

// File: rtl/tbc_sched_ctrl.sv
module tbc_sched_ctrl #(
  parameter int STEPS = 10,
  parameter int RPS   = 2,
  parameter int RC_W  = 16,
  parameter int STEP_SH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            load_o,
  output logic            run_o,
  output logic            tk_upd_o,
  output logic            fin_o,
  output logic [RC_W-1:0] rc_o,
  output logic            done_o
);
  import tbc_seq_pkg::*;

  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int RND_W  = (RPS > 1) ? $clog2(RPS) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);
  localparam logic [RND_W-1:0]  RND_LAST  = RND_W'(RPS - 1);

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;
  logic              done_q, done_d;
  logic              running, last_rnd, last_step;

  assign running   = (st_q == SEQ_RUN);
  assign last_rnd  = (rnd_q == RND_LAST);
  assign last_step = (step_q == STEP_LAST);

  // Next-state process
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          st_d   = SEQ_RUN;
          step_d = '0;
          rnd_d  = '0;
        end
      end
      SEQ_RUN: begin
        if (last_rnd) begin
          rnd_d = '0;
          if (last_step) begin
            st_d   = SEQ_IDLE;
            step_d = '0;
            done_d = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end else begin
          rnd_d = rnd_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      step_q <= '0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  assign load_o   = (st_q == SEQ_IDLE) && start_i;
  assign run_o    = running;
  assign tk_upd_o = running && last_rnd;
  assign fin_o    = running && last_rnd && last_step;
  assign done_o   = done_q;
  assign rc_o     = (RC_W'(step_q) << STEP_SH) | RC_W'(rnd_q);

endmodule

// File: rtl/tbc_round_dp.sv
module tbc_round_dp #(
  parameter int BLK_W   = 128,
  parameter int RC_W    = 16,
  parameter int TWK_ROT = 8,
  parameter int LIN_A   = 29,
  parameter int LIN_B   = 77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tk_upd_i,
  input  logic             fin_i,
  input  logic [RC_W-1:0]  rc_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] tweak_i,
  output logic [BLK_W-1:0] result_o
);
  logic [BLK_W-1:0] state_q, state_d;
  logic [BLK_W-1:0] key_q, key_d;
  logic [BLK_W-1:0] twk_q, twk_d;
  logic [BLK_W-1:0] res_q, res_d;
  logic             state_en, key_en, twk_en, res_en;
  logic [BLK_W-1:0] tk, mix_in, sub_out, lin_out, twk_rot;

  assign tk     = key_q ^ twk_q;
  assign mix_in = state_q ^ tk ^ BLK_W'(rc_i);

  tbc_sub_layer #(.BLK_W(BLK_W)) i_sub (
    .din  (mix_in),
    .dout (sub_out)
  );

  assign lin_out = sub_out
                 ^ ((sub_out << LIN_A) | (sub_out >> (BLK_W - LIN_A)))
                 ^ ((sub_out << LIN_B) | (sub_out >> (BLK_W - LIN_B)));

  assign twk_rot = (twk_q << TWK_ROT) | (twk_q >> (BLK_W - TWK_ROT));

  // Next-state process with explicit enables
  always_comb begin
    state_en = load_i | run_i;
    state_d  = load_i ? block_i : lin_out;
    key_en   = load_i;
    key_d    = key_i;
    twk_en   = load_i | (run_i & tk_upd_i);
    twk_d    = load_i ? tweak_i : twk_rot;
    res_en   = fin_i;
    res_d    = lin_out;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      key_q   <= '0;
      twk_q   <= '0;
      res_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (key_en)   key_q   <= key_d;
      if (twk_en)   twk_q   <= twk_d;
      if (res_en)   res_q   <= res_d;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/tbc_round_seq.sv
module tbc_round_seq #(
  parameter int BLK_W   = 128,
  parameter int STEPS   = 10,
  parameter int RPS     = 2,
  parameter int RC_W    = 16,
  parameter int STEP_SH = 8,
  parameter int TWK_ROT = 8,
  parameter int LIN_A   = 29,
  parameter int LIN_B   = 77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] tweak_i,
  output logic             busy_o,
  output logic             tk_upd_o,
  output logic [RC_W-1:0]  rc_o,
  output logic             done_o,
  output logic [BLK_W-1:0] result_o
);
  logic load, run, tk_upd, fin;
  logic [RC_W-1:0] rc;

  tbc_sched_ctrl #(
    .STEPS(STEPS), .RPS(RPS), .RC_W(RC_W), .STEP_SH(STEP_SH)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .load_o   (load),
    .run_o    (run),
    .tk_upd_o (tk_upd),
    .fin_o    (fin),
    .rc_o     (rc),
    .done_o   (done_o)
  );

  tbc_round_dp #(
    .BLK_W(BLK_W), .RC_W(RC_W), .TWK_ROT(TWK_ROT), .LIN_A(LIN_A), .LIN_B(LIN_B)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .run_i    (run),
    .tk_upd_i (tk_upd),
    .fin_i    (fin),
    .rc_i     (rc),
    .block_i  (block_i),
    .key_i    (key_i),
    .tweak_i  (tweak_i),
    .result_o (result_o)
  );

  assign busy_o   = run;
  assign tk_upd_o = tk_upd;
  assign rc_o     = rc;

endmodule

// File: rtl/tbc_round_seq_chk.sv
module tbc_round_seq_chk #(
  parameter int BLK_W = 128,
  parameter int STEPS = 10,
  parameter int RC_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             tk_upd_o,
  input logic [RC_W-1:0]  rc_o,
  input logic             done_o,
  input logic [BLK_W-1:0] result_o
);
  localparam logic [3:0] LAST_STEP = 4'(STEPS - 1);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R4
  rc_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rc_o[15:12] == 4'h0 && rc_o[7:1] == 7'h0 && rc_o[11:8] <= LAST_STEP));

  // R4
  round_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rc_o[0]) |=> (busy_o && rc_o[0] && $stable(rc_o[11:8])));

  // R4
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rc_o[0] && rc_o[11:8] != LAST_STEP)
      |=> (busy_o && !rc_o[0] && rc_o[11:8] == $past(rc_o[11:8]) + 4'd1));

  // R3
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rc_o[0] && rc_o[11:8] == LAST_STEP) |=> (done_o && !busy_o));

  // R5
  tk_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tk_upd_o |-> (busy_o && rc_o[0]));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(rc_o[0] && rc_o[11:8] == LAST_STEP)) |=> busy_o);

endmodule

bind tbc_round_seq tbc_round_seq_chk #(.BLK_W(BLK_W), .STEPS(STEPS), .RC_W(RC_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .tk_upd_o (tk_upd_o),
  .rc_o     (rc_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_tbc_round_seq.sv
`timescale 1ns/1ps
module test_tbc_round_seq;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [127:0] block_i, key_i, tweak_i;
  logic         busy_o, tk_upd_o, done_o;
  logic [15:0]  rc_o;
  logic [127:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [127:0] prev_res;

  tbc_round_seq i_tbc_round_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .block_i(block_i), .key_i(key_i), .tweak_i(tweak_i),
    .busy_o(busy_o), .tk_upd_o(tk_upd_o), .rc_o(rc_o),
    .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rl(input logic [127:0] x, input int n);
    return (x << n) | (x >> (128 - n));
  endfunction

  function automatic logic [7:0] byte_map(input logic [7:0] b);
    return b ^ ({b[6:0], b[7]} & {b[5:0], b[7:6]}) ^ 8'h5A;
  endfunction

  // Model of R6
  function automatic logic [127:0] model(input logic [127:0] blk, input logic [127:0] key,
                                         input logic [127:0] twk);
    logic [127:0] st, t, x, y;
    logic [15:0]  rc;
    st = blk;
    t  = twk;
    for (int s = 0; s < 10; s++) begin
      for (int r = 0; r < 2; r++) begin
        rc = {4'h0, 4'(s), 7'h0, 1'(r)};
        x  = st ^ key ^ t ^ {112'h0, rc};
        for (int b = 0; b < 16; b++) y[b*8 +: 8] = byte_map(x[b*8 +: 8]);
        st = y ^ rl(y, 29) ^ rl(y, 77);
      end
      t = rl(t, 8);
    end
    return st;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // inj: busy cycle in which a stray start is driven (-1 = none)
  task automatic run_block(input logic [127:0] blk, input logic [127:0] key,
                           input logic [127:0] twk, input int inj);
    logic [127:0] exp;
    logic [15:0]  rc_exp;
    int           nupd;
    exp  = model(blk, key, twk);
    nupd = 0;
    @(negedge clk);
    start_i = 1'b1; block_i = blk; key_i = key; tweak_i = twk;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      rc_exp = {4'h0, 4'(i / 2), 7'h0, 1'(i % 2)};
      check(busy_o === 1'b1, "R2 busy during run", 128'(busy_o), 128'(1));
      check(rc_o === rc_exp, "R4 round constant", 128'(rc_o), 128'(rc_exp));
      check(tk_upd_o === 1'(i % 2), "R5 tweak refresh strobe", 128'(tk_upd_o), 128'(i % 2));
      check(done_o === 1'b0, "R3 no early done", 128'(done_o), 128'(0));
      check(result_o === prev_res, "R7 result held while busy", result_o, prev_res);
      if (tk_upd_o === 1'b1) nupd++;
      if (i == inj) begin
        start_i = 1'b1; block_i = ~blk; key_i = ~key; tweak_i = ~twk;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    check(nupd == 10, "R5 refresh count", 128'(nupd), 128'(10));
    check(done_o === 1'b1, "R3 done at edge 20", 128'(done_o), 128'(1));
    check(busy_o === 1'b0, "R3 idle with done", 128'(busy_o), 128'(0));
    check(result_o === exp, (inj >= 0) ? "R8 result unaffected by stray start" : "R6 result",
          result_o, exp);
    prev_res = exp;
    @(negedge clk);
    check(done_o === 1'b0, "R3 done lasts one cycle", 128'(done_o), 128'(0));
    check(busy_o === 1'b0, "R8 stray start not accepted", 128'(busy_o), 128'(0));
    check(result_o === prev_res, "R7 result held when idle", result_o, prev_res);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1D5E_0A17));
    rst_n = 1'b0; start_i = 1'b0;
    block_i = '0; key_i = '0; tweak_i = '0;
    prev_res = '0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && tk_upd_o === 1'b0, "R1 reset flags",
          128'({busy_o, done_o, tk_upd_o}), 128'(0));
    check(rc_o === 16'h0, "R1 reset rc", 128'(rc_o), 128'(0));
    check(result_o === '0, "R1 reset result", result_o, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0, "R1 idle after release", 128'(busy_o), 128'(0));

    // Directed corners
    run_block('0, '0, '0, -1);
    run_block({128{1'b1}}, {128{1'b1}}, {128{1'b1}}, -1);
    run_block(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h1, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 0);
    run_block(rnd128(), rnd128(), rnd128(), 19);
    run_block(rnd128(), rnd128(), rnd128(), 7);

    // Random blocks
    for (int k = 0; k < 8; k++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      run_block(rnd128(), rnd128(), rnd128(), (k % 3 == 0) ? int'($urandom_range(0, 19)) : -1);
    end

    // Reset in the middle of a block
    @(negedge clk);
    start_i = 1'b1; block_i = rnd128();
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b0 && rc_o === 16'h0, "R1 mid-block reset",
          128'({busy_o, rc_o}), 128'(0));
    check(result_o === '0, "R1 mid-block reset result", result_o, 128'(0));
    rst_n = 1'b1;
    prev_res = '0;
    @(negedge clk);
    check(busy_o === 1'b0, "R1 idle after mid-block reset", 128'(busy_o), 128'(0));
    run_block(rnd128(), rnd128(), rnd128(), -1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule